// File: doc/BRIEF.md
# Next-Fetch Address Predictor with Counter-Filtered Target Cache

This block tells a single-issue fetch unit where to fetch next. A small, fully associative target cache maps branch addresses to the targets they last jumped to. A larger, untagged, direct-mapped table of 2-bit saturating counters records how often each branch goes each way. Each cycle the fetch address is presented on the lookup port. If it matches a cached branch, the stored target becomes the next fetch address. Otherwise the next fetch address is the sequential one, the current address plus one instruction (`2**ALIGN` bytes).

When a branch resolves, its address, direction and target arrive on the update port. The counter selected by that address always moves one step toward the outcome. The target cache follows the counter's opinion as it stood before this update. A taken branch is written into the cache only when the counter already favoured taken. A not-taken branch loses its cache entry only when the counter already favoured not-taken. One odd outcome is therefore not enough to add or drop an entry.

The lookup port is purely combinational. The update port is a stream input qualified by `upd_valid` and has no ready signal, because the block accepts one update in every cycle. The sender never sees back-pressure, and an update is consumed at the clock edge where `upd_valid` is high.

Top module: `fp_next_fetch`

## Requirements
- R1: After reset every cache entry is empty and every counter holds 1 (weakly not-taken). Every lookup therefore misses and reports a not-taken prediction.
- R2: On a lookup hit, `lk_next` equals the stored target. On a miss, `lk_next` equals `lk_pc + 2**ALIGN` (4 by default).
- R3: Counters are indexed by `pc[ALIGN +: log2(CTR_N)]` and carry no tag, so two addresses that agree in those bits share one counter. `lk_pred_taken` is bit 1 of the counter, which means taken for values 2 and 3.
- R4: An accepted update raises the counter by one on taken and lowers it by one on not-taken. The counter saturates at 3 and at 0.
- R5: A taken update writes the cache only if the counter value before that update was 2 or 3.
- R6: A not-taken update invalidates a matching cache entry only if the counter value before that update was 0 or 1.
- R7: A taken, allowed write whose address is already cached replaces that entry's target in place. It uses no new slot and does not move the replacement pointer.
- R8: A new entry goes into the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on every new insertion. Entries made invalid by eviction keep their slot order.
- R9: A lookup in the same cycle as an update to the same address returns the contents from before that update. The new contents are visible from the next cycle.
- R10: The update port is never stalled. While `upd_valid` is low, neither the cache nor any counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Current fetch address |
| lk_hit | output | 1 | Fetch address found in the target cache |
| lk_target | output | 32 | Cached target (zero on miss) |
| lk_next | output | 32 | Predicted next fetch address |
| lk_pred_taken | output | 1 | Direction from the counter for `lk_pc` |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any update arrives. They also assume that the update inputs are stable around the edge where they are sampled. The bench meets both conditions by holding reset for several cycles and by changing every input only on the falling edge. Addresses are kept word-aligned throughout. The properties check counter stepping, the at-most-one match on lookup, and the rules that freeze the valid set. Addresses are chosen so that counter sharing and slot reuse occur only where a test intends them.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [1:0] ctr_t;

  function automatic ctr_t ctr_step(ctr_t cur, logic taken);
    if (taken) return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else       return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
  endfunction
endpackage

// File: rtl/fp_ctr_table.sv
module fp_ctr_table
  import fp_pkg::*;
#(
  parameter int unsigned CTR_N = 64,
  parameter int unsigned ALIGN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  addr_t             rd_pc,
  output logic              rd_pred,
  input  logic              up_valid,
  input  addr_t             up_pc,
  input  logic              up_taken,
  output ctr_t              up_old,
  output logic [2*CTR_N-1:0] ctr_flat
);
  localparam int unsigned IDX_W = $clog2(CTR_N);

  ctr_t ctr_q [CTR_N];
  logic [IDX_W-1:0] rd_idx, up_idx;

  assign rd_idx  = rd_pc[ALIGN +: IDX_W];
  assign up_idx  = up_pc[ALIGN +: IDX_W];
  assign rd_pred = ctr_q[rd_idx][1];
  assign up_old  = ctr_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CTR_N; i++) ctr_q[i] <= 2'd1;
    end else if (up_valid) begin
      ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
    end
  end

  for (genvar g = 0; g < CTR_N; g++) begin : g_flat
    assign ctr_flat[2*g +: 2] = ctr_q[g];
  end
endmodule

// File: rtl/fp_btb.sv
module fp_btb
  import fp_pkg::*;
#(
  parameter int unsigned BTB_N = 4,
  parameter int unsigned ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  addr_t            lk_pc,
  output logic             lk_hit,
  output addr_t            lk_target,
  output logic [BTB_N-1:0] lk_match,
  input  logic             wr_en,
  input  logic             ev_en,
  input  addr_t            up_pc,
  input  addr_t            up_target,
  output logic             up_present,
  output logic [BTB_N-1:0] vld_q
);
  localparam int unsigned TAG_W = ADDR_W - ALIGN;
  localparam int unsigned PTR_W = (BTB_N > 1) ? $clog2(BTB_N) : 1;

  logic [TAG_W-1:0] tag_q [BTB_N];
  addr_t            tgt_q [BTB_N];
  logic [BTB_N-1:0] up_match;
  logic [PTR_W-1:0] ptr_q;

  for (genvar g = 0; g < BTB_N; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_pc[ADDR_W-1:ALIGN]);
    assign up_match[g] = vld_q[g] && (tag_q[g] == up_pc[ADDR_W-1:ALIGN]);
  end

  assign lk_hit     = |lk_match;
  assign up_present = |up_match;

  always_comb begin
    lk_target = '0;
    for (int i = 0; i < BTB_N; i++)
      if (lk_match[i]) lk_target = lk_target | tgt_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < BTB_N; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (up_present) begin
        for (int i = 0; i < BTB_N; i++)
          if (up_match[i]) tgt_q[i] <= up_target;
      end else begin
        vld_q[ptr_q] <= 1'b1;
        tag_q[ptr_q] <= up_pc[ADDR_W-1:ALIGN];
        tgt_q[ptr_q] <= up_target;
        ptr_q <= (ptr_q == PTR_W'(BTB_N - 1)) ? '0 : ptr_q + 1'b1;
      end
    end else if (ev_en) begin
      for (int i = 0; i < BTB_N; i++)
        if (up_match[i]) vld_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_next_fetch.sv
module fp_next_fetch
  import fp_pkg::*;
#(
  parameter int unsigned BTB_N = 4,
  parameter int unsigned CTR_N = 64,
  parameter int unsigned ALIGN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lk_pc,
  output logic        lk_hit,
  output logic [31:0] lk_target,
  output logic [31:0] lk_next,
  output logic        lk_pred_taken,
  input  logic        upd_valid,
  input  logic [31:0] upd_pc,
  input  logic        upd_taken,
  input  logic [31:0] upd_target
);
  localparam addr_t STEP = addr_t'(1) << ALIGN;

  ctr_t               upd_old;
  logic [2*CTR_N-1:0] ctr_flat;
  logic [BTB_N-1:0]   lk_match;
  logic [BTB_N-1:0]   vld_q;
  logic               up_present;
  logic               wr_en, ev_en;

  fp_ctr_table #(.CTR_N(CTR_N), .ALIGN(ALIGN)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(lk_pc), .rd_pred(lk_pred_taken),
    .up_valid(upd_valid), .up_pc(upd_pc), .up_taken(upd_taken),
    .up_old(upd_old), .ctr_flat(ctr_flat)
  );

  // Gating uses the counter value before this resolution's own step.
  assign wr_en = upd_valid &&  upd_taken &&  upd_old[1];
  assign ev_en = upd_valid && !upd_taken && !upd_old[1];

  fp_btb #(.BTB_N(BTB_N), .ALIGN(ALIGN)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target), .lk_match(lk_match),
    .wr_en(wr_en), .ev_en(ev_en),
    .up_pc(upd_pc), .up_target(upd_target),
    .up_present(up_present), .vld_q(vld_q)
  );

  assign lk_next = lk_hit ? lk_target : lk_pc + STEP;
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int unsigned BTB_N = 4,
  parameter int unsigned CTR_N = 64,
  parameter int unsigned ALIGN = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [31:0]        upd_pc,
  input logic [1:0]         upd_old,
  input logic [2*CTR_N-1:0] ctr_flat,
  input logic [BTB_N-1:0]   lk_match,
  input logic [BTB_N-1:0]   vld_q
);
  localparam int unsigned IDX_W = $clog2(CTR_N);

  logic             seen_q, tk_q;
  logic [1:0]       old_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       now_ctr, want_ctr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0; tk_q <= 1'b0; old_q <= '0; idx_q <= '0;
    end else begin
      seen_q <= upd_valid;
      tk_q   <= upd_taken;
      old_q  <= upd_old;
      idx_q  <= upd_pc[ALIGN +: IDX_W];
    end
  end

  assign now_ctr  = ctr_flat[2*idx_q +: 2];
  assign want_ctr = tk_q ? ((old_q == 2'd3) ? 2'd3 : old_q + 2'd1)
                         : ((old_q == 2'd0) ? 2'd0 : old_q - 2'd1);

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> now_ctr == want_ctr);

  p_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !upd_old[1]) |=> vld_q == $past(vld_q));

  p_no_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_old[1]) |=> vld_q == $past(vld_q));

  p_one_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) <= $countones($past(vld_q)) + 1);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (vld_q == $past(vld_q)) && (ctr_flat == $past(ctr_flat)));
endmodule

bind fp_next_fetch fp_checker #(.BTB_N(BTB_N), .CTR_N(CTR_N), .ALIGN(ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_pc(upd_pc), .upd_old(upd_old), .ctr_flat(ctr_flat),
  .lk_match(lk_match), .vld_q(vld_q)
);

// File: tb/test_fp_next_fetch.sv
module test_fp_next_fetch;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_pred_taken;
  logic [31:0] lk_target, lk_next;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_next_fetch i_fp_next_fetch (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_target(lk_target), .lk_next(lk_next), .lk_pred_taken(lk_pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic upd(logic [31:0] pc, logic tk, logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(logic [31:0] pc);
    lk_pc = pc;
    #1;
  endtask

  task automatic t_reset;
    look(32'h100);
    check("R1 hit", {31'd0, lk_hit}, 32'd0);
    check("R1 pred", {31'd0, lk_pred_taken}, 32'd0);
    check("R2 seq next", lk_next, 32'h104);
  endtask

  task automatic t_insert_gate;
    upd(32'h40, 1'b1, 32'h800);
    look(32'h40);
    check("R5 no insert at weak", {31'd0, lk_hit}, 32'd0);
    check("R4 inc to 2", {31'd0, lk_pred_taken}, 32'd1);
    upd(32'h40, 1'b1, 32'h800);
    look(32'h40);
    check("R5 insert at strong", {31'd0, lk_hit}, 32'd1);
    check("R2 target next", lk_next, 32'h800);
  endtask

  task automatic t_saturate_evict;
    upd(32'h40, 1'b1, 32'h800);
    upd(32'h40, 1'b1, 32'h800);   // r4_ saturates at 3
    upd(32'h40, 1'b0, 32'h0);     // 3 -> 2
    look(32'h40);
    check("R4 sat high", {31'd0, lk_pred_taken}, 32'd1);
    check("R6 keep at 3", {31'd0, lk_hit}, 32'd1);
    upd(32'h40, 1'b0, 32'h0);     // 2 -> 1, no evict
    look(32'h40);
    check("R6 keep at 2", {31'd0, lk_hit}, 32'd1);
    check("R4 dec to 1", {31'd0, lk_pred_taken}, 32'd0);
    upd(32'h40, 1'b0, 32'h0);     // 1 -> 0, evict
    look(32'h40);
    check("R6 evict at 1", {31'd0, lk_hit}, 32'd0);
    upd(32'h40, 1'b0, 32'h0);     // stays 0
    upd(32'h40, 1'b1, 32'h800);   // 0 -> 1
    look(32'h40);
    check("R4 sat low", {31'd0, lk_pred_taken}, 32'd0);
  endtask

  task automatic t_alias;
    upd(32'h80, 1'b1, 32'h0);
    look(32'h180);
    check("R3 shared counter", {31'd0, lk_pred_taken}, 32'd1);
    look(32'h84);
    check("R3 neighbour", {31'd0, lk_pred_taken}, 32'd0);
    check("R3 alias no hit", {31'd0, lk_hit}, 32'd0);
  endtask

  task automatic t_refresh;
    upd(32'h10, 1'b1, 32'h900);
    upd(32'h10, 1'b1, 32'h900);
    upd(32'h10, 1'b1, 32'hA00);
    look(32'h10);
    check("R7 refresh target", lk_next, 32'hA00);
  endtask

  task automatic t_round_robin;
    // slots so far: 0=0x40 (evicted), 1=0x10; pointer at 2
    for (int k = 0; k < 4; k++) begin
      upd(32'h20 + 32'(k) * 4, 1'b1, 32'hC00 + 32'(k) * 16);
      upd(32'h20 + 32'(k) * 4, 1'b1, 32'hC00 + 32'(k) * 16);
    end
    look(32'h10);
    check("R8 slot1 replaced", {31'd0, lk_hit}, 32'd0);
    upd(32'h30, 1'b1, 32'hD00);
    upd(32'h30, 1'b1, 32'hD00);
    look(32'h20);
    check("R8 slot2 replaced", {31'd0, lk_hit}, 32'd0);
    look(32'h24);
    check("R8 slot3 kept", lk_next, 32'hC10);
    look(32'h30);
    check("R8 newest", lk_next, 32'hD00);
  endtask

  task automatic t_same_cycle;
    upd(32'h34, 1'b1, 32'hE00);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h34; upd_taken = 1'b1; upd_target = 32'hE00;
    look(32'h34);
    check("R9 old view", {31'd0, lk_hit}, 32'd0);
    @(negedge clk);
    upd_valid = 1'b0;
    look(32'h34);
    check("R9 new view", lk_next, 32'hE00);
  endtask

  task automatic t_idle;
    @(negedge clk);
    upd_pc = 32'h34; upd_taken = 1'b0; upd_target = 32'h0; upd_valid = 1'b0;
    repeat (4) @(negedge clk);
    look(32'h34);
    check("R10 entry kept", {31'd0, lk_hit}, 32'd1);
    check("R10 counter kept", {31'd0, lk_pred_taken}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_insert_gate();
    t_saturate_evict();
    t_alias();
    t_refresh();
    t_round_robin();
    t_same_cycle();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule